// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer and Decoder

This block sits between an 8-bit processor whose low address byte and data byte share one set of lines and a plain memory and I/O system. During the early part of each machine cycle the processor raises an address strobe while the shared lines carry the low address byte. The block passes that byte through and captures it. When the strobe drops and the lines turn over to data, the block goes on presenting the captured byte. The dedicated high address byte is joined to it to form a full 16-bit address.

The processor signals a transfer with an active-low read, an active-low write and a space select (0 = memory, 1 = I/O). The block turns these into four separate active-low command strobes: memory read, memory write, I/O read and I/O write. Address bits 15 to 10 pick one 1 KB memory region, and each populated region gets an active-low chip select. Bits 9 to 0 go straight to the memory chips on the address output. The block also steers the split data path. Data travels toward the processor only during a read, and toward the system only during a write, so two drivers never meet.

Top module: `mbus_demux_top`

## Requirements
- R1: While the internal reset is active, the held low address byte is cleared to 0x00. After reset, with the strobe low, `addr_o[7:0]` reads 0x00.
- R2: While `addr_stb_i` is 1, `addr_o[7:0]` equals `ad_i` in the same cycle. At all times `addr_o[15:8]` equals `addr_hi_i`.
- R3: While `addr_stb_i` is 0, `addr_o[7:0]` equals the value `ad_i` had at the last rising clock edge at which the strobe was 1. Changes on `ad_i` during the data phase have no effect on it.
- R4: `mem_rd_n_o` is 0 exactly when `io_sel_i`=0, `rd_n_i`=0, `wr_n_i`=1 and `addr_stb_i`=0.
- R5: `mem_wr_n_o` is 0 exactly when `io_sel_i`=0, `wr_n_i`=0, `rd_n_i`=1 and `addr_stb_i`=0.
- R6: `io_rd_n_o` and `io_wr_n_o` follow the same rules as R4 and R5, but with `io_sel_i`=1.
- R7: At most one of the four command strobes is 0 at any time. If read and write are both 0, all four stay 1.
- R8: `cs_n_o[k]` is 0 exactly when `io_sel_i`=0 and `addr_o[15:10]` equals k, for k below NUM_CS. Region codes NUM_CS and above select nothing, and every select stays 1 during an I/O operation.
- R9: `cpu_oe_o` is 1 exactly when a read strobe (memory or I/O) is active, and `sys_oe_o` is 1 exactly when a write strobe is active. The two are never 1 together.
- R10: `cpu_dat_o` equals `sys_dat_i` while `cpu_oe_o` is 1 and 0x00 otherwise. `sys_dat_o` equals `ad_i` while `sys_oe_o` is 1 and 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_stb_i | input | 1 | Address strobe; 1 while the shared lines carry the low address |
| addr_hi_i | input | 8 | Dedicated high address byte |
| ad_i | input | 8 | Shared lines as driven by the processor (address, then write data) |
| rd_n_i | input | 1 | Read request, active low |
| wr_n_i | input | 1 | Write request, active low |
| io_sel_i | input | 1 | Space select: 0 memory, 1 I/O |
| sys_dat_i | input | 8 | Read data returned by memory or I/O |
| addr_o | output | 16 | Demultiplexed full address |
| mem_rd_n_o | output | 1 | Memory read strobe, active low |
| mem_wr_n_o | output | 1 | Memory write strobe, active low |
| io_rd_n_o | output | 1 | I/O read strobe, active low |
| io_wr_n_o | output | 1 | I/O write strobe, active low |
| cs_n_o | output | NUM_CS | Active-low 1 KB region selects |
| cpu_oe_o | output | 1 | Enables the drivers toward the processor |
| cpu_dat_o | output | 8 | Data toward the processor |
| sys_oe_o | output | 1 | Enables the drivers toward the system |
| sys_dat_o | output | 8 | Write data toward the system |

## Verification
The two functions that can fall in the same cycle are the address phase and a command. A processor that drops read or write while the strobe is still high would enable a driver during the address phase and contend with the address byte. The bench provokes this deliberately by holding read low with the strobe high. It also asserts read and write together, and it drives data-phase values on the shared lines while a command is active. On every clock a behavioural model predicts the address, the strobes, the selects and the enables, and the bench compares the outputs against it. The bench expects every command, and both data enables, to stay inactive while the strobe is high, and the held address to stay unchanged while the data byte moves.

// File: rtl/mbus_demux_pkg.sv
package mbus_demux_pkg;
  // Decoded command, active high inside the block.
  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic io_rd;
    logic io_wr;
  } cmd_t;
endpackage

// File: rtl/mbus_lo_latch.sv
module mbus_lo_latch #(
  parameter int LO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stb,
  input  logic [LO_W-1:0] lo_i,
  output logic [LO_W-1:0] lo_o
);
  logic [LO_W-1:0] held_q;
  logic [LO_W-1:0] held_d;

  // Next-state: capture while the strobe is high, otherwise keep.
  always_comb begin
    held_d = held_q;
    if (stb) held_d = lo_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  // Transparent path during the address phase.
  assign lo_o = stb ? lo_i : held_q;
endmodule

// File: rtl/mbus_cmd_decode.sv
module mbus_cmd_decode
  import mbus_demux_pkg::*;
(
  input  logic rd_n,
  input  logic wr_n,
  input  logic io_sel,
  input  logic addr_phase,
  output cmd_t cmd
);
  logic rd_req;
  logic wr_req;

  // A request counts only outside the address phase and only when the
  // other direction is idle, so conflicting requests yield nothing.
  assign rd_req = !rd_n && wr_n && !addr_phase;
  assign wr_req = !wr_n && rd_n && !addr_phase;

  always_comb begin
    cmd        = '0;
    cmd.mem_rd = rd_req && !io_sel;
    cmd.mem_wr = wr_req && !io_sel;
    cmd.io_rd  = rd_req &&  io_sel;
    cmd.io_wr  = wr_req &&  io_sel;
  end
endmodule

// File: rtl/mbus_cs_decode.sv
module mbus_cs_decode #(
  parameter int SEL_W  = 6,
  parameter int NUM_CS = 8
) (
  input  logic              en,
  input  logic [SEL_W-1:0]  sel,
  output logic [NUM_CS-1:0] cs_n
);
  for (genvar k = 0; k < NUM_CS; k++) begin : g_region
    localparam logic [SEL_W-1:0] CODE = SEL_W'(k);
    assign cs_n[k] = !(en && (sel == CODE));
  end
endmodule

// File: rtl/mbus_dir_ctrl.sv
module mbus_dir_ctrl
  import mbus_demux_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  cmd_t              cmd,
  input  logic [DATA_W-1:0] cpu_wdat,
  input  logic [DATA_W-1:0] sys_rdat,
  output logic              cpu_oe,
  output logic [DATA_W-1:0] cpu_dat,
  output logic              sys_oe,
  output logic [DATA_W-1:0] sys_dat
);
  assign cpu_oe  = cmd.mem_rd || cmd.io_rd;
  assign sys_oe  = cmd.mem_wr || cmd.io_wr;
  assign cpu_dat = cpu_oe ? sys_rdat : '0;
  assign sys_dat = sys_oe ? cpu_wdat : '0;
endmodule

// File: rtl/mbus_demux_top.sv
module mbus_demux_top
  import mbus_demux_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int REGION_BITS = 10,
  parameter int NUM_CS      = 8,
  localparam int HI_W       = ADDR_W - DATA_W,
  localparam int SEL_W      = ADDR_W - REGION_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_stb_i,
  input  logic [HI_W-1:0]   addr_hi_i,
  input  logic [DATA_W-1:0] ad_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic              io_sel_i,
  input  logic [DATA_W-1:0] sys_dat_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              mem_rd_n_o,
  output logic              mem_wr_n_o,
  output logic              io_rd_n_o,
  output logic              io_wr_n_o,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              cpu_oe_o,
  output logic [DATA_W-1:0] cpu_dat_o,
  output logic              sys_oe_o,
  output logic [DATA_W-1:0] sys_dat_o
);
  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [DATA_W-1:0] lo_addr;
  cmd_t              cmd;

  mbus_lo_latch #(.LO_W(DATA_W)) u_latch (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .stb  (addr_stb_i),
    .lo_i (ad_i),
    .lo_o (lo_addr)
  );

  assign addr_o = {addr_hi_i, lo_addr};

  mbus_cmd_decode u_cmd (
    .rd_n      (rd_n_i),
    .wr_n      (wr_n_i),
    .io_sel    (io_sel_i),
    .addr_phase(addr_stb_i),
    .cmd       (cmd)
  );

  assign mem_rd_n_o = !cmd.mem_rd;
  assign mem_wr_n_o = !cmd.mem_wr;
  assign io_rd_n_o  = !cmd.io_rd;
  assign io_wr_n_o  = !cmd.io_wr;

  mbus_cs_decode #(.SEL_W(SEL_W), .NUM_CS(NUM_CS)) u_cs (
    .en  (!io_sel_i),
    .sel (addr_o[ADDR_W-1:REGION_BITS]),
    .cs_n(cs_n_o)
  );

  mbus_dir_ctrl #(.DATA_W(DATA_W)) u_dir (
    .cmd     (cmd),
    .cpu_wdat(ad_i),
    .sys_rdat(sys_dat_i),
    .cpu_oe  (cpu_oe_o),
    .cpu_dat (cpu_dat_o),
    .sys_oe  (sys_oe_o),
    .sys_dat (sys_dat_o)
  );
endmodule

// File: rtl/mbus_demux_chk.sv
module mbus_demux_chk #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int REGION_BITS = 10,
  parameter int NUM_CS      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_stb_i,
  input logic [DATA_W-1:0] ad_i,
  input logic              rd_n_i,
  input logic              wr_n_i,
  input logic              io_sel_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              mem_rd_n_o,
  input logic              mem_wr_n_o,
  input logic              io_rd_n_o,
  input logic              io_wr_n_o,
  input logic [NUM_CS-1:0] cs_n_o,
  input logic              cpu_oe_o,
  input logic              sys_oe_o
);
  // One cycle of history after reset before $past is trusted.
  logic hist_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= 1'b1;
  end

  assert_transparent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb_i |-> (addr_o[DATA_W-1:0] == ad_i));

  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_q && $past(addr_stb_i) && !addr_stb_i) |-> (addr_o[DATA_W-1:0] == $past(ad_i)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_q && !$past(addr_stb_i) && !addr_stb_i) |-> $stable(addr_o[DATA_W-1:0]));

  assert_mem_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n_o |-> (!io_sel_i && !rd_n_i && wr_n_i && !addr_stb_i));

  assert_mem_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n_o |-> (!io_sel_i && !wr_n_i && rd_n_i && !addr_stb_i));

  assert_io_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_rd_n_o || !io_wr_n_o) |-> (io_sel_i && !addr_stb_i));

  assert_one_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o}) >= 3);

  assert_cs_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n_o));

  assert_cs_io_R8: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel_i |-> (&cs_n_o));

  assert_oe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_oe_o && sys_oe_o));

  assert_oe_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb_i |-> (!cpu_oe_o && !sys_oe_o));
endmodule

bind mbus_demux_top mbus_demux_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REGION_BITS(REGION_BITS), .NUM_CS(NUM_CS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_q),
  .addr_stb_i(addr_stb_i),
  .ad_i      (ad_i),
  .rd_n_i    (rd_n_i),
  .wr_n_i    (wr_n_i),
  .io_sel_i  (io_sel_i),
  .addr_o    (addr_o),
  .mem_rd_n_o(mem_rd_n_o),
  .mem_wr_n_o(mem_wr_n_o),
  .io_rd_n_o (io_rd_n_o),
  .io_wr_n_o (io_wr_n_o),
  .cs_n_o    (cs_n_o),
  .cpu_oe_o  (cpu_oe_o),
  .sys_oe_o  (sys_oe_o)
);

// File: tb/tb_mbus_demux_top.sv
`timescale 1ns/1ps
module tb_mbus_demux_top;
  localparam int NCS = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        addr_stb_i;
  logic [7:0]  addr_hi_i;
  logic [7:0]  ad_i;
  logic        rd_n_i;
  logic        wr_n_i;
  logic        io_sel_i;
  logic [7:0]  sys_dat_i;
  logic [15:0] addr_o;
  logic        mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o;
  logic [NCS-1:0] cs_n_o;
  logic        cpu_oe_o, sys_oe_o;
  logic [7:0]  cpu_dat_o, sys_dat_o;

  always #2.5 clk = ~clk;

  mbus_demux_top dut (
    .clk(clk), .rst_n(rst_n), .addr_stb_i(addr_stb_i), .addr_hi_i(addr_hi_i),
    .ad_i(ad_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .io_sel_i(io_sel_i),
    .sys_dat_i(sys_dat_i), .addr_o(addr_o), .mem_rd_n_o(mem_rd_n_o),
    .mem_wr_n_o(mem_wr_n_o), .io_rd_n_o(io_rd_n_o), .io_wr_n_o(io_wr_n_o),
    .cs_n_o(cs_n_o), .cpu_oe_o(cpu_oe_o), .cpu_dat_o(cpu_dat_o),
    .sys_oe_o(sys_oe_o), .sys_dat_o(sys_dat_o)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0] held_ref;
  logic [7:0] held_log[$];

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: prediction from inputs and the modelled held byte.
  task automatic compare();
    logic [15:0] a;
    logic rd_ok, wr_ok;
    logic mr, mw, ir, iw;
    logic [NCS-1:0] cs;
    a     = {addr_hi_i, addr_stb_i ? ad_i : held_ref};
    rd_ok = !rd_n_i && wr_n_i && !addr_stb_i;
    wr_ok = !wr_n_i && rd_n_i && !addr_stb_i;
    mr = rd_ok && !io_sel_i;  mw = wr_ok && !io_sel_i;
    ir = rd_ok &&  io_sel_i;  iw = wr_ok &&  io_sel_i;
    cs = '1;
    if (!io_sel_i && int'(a[15:10]) < NCS) cs[a[15:10]] = 1'b0;
    chk("R2 addr_hi", {8'h0, addr_o[15:8]}, {8'h0, addr_hi_i});
    chk(addr_stb_i ? "R2 addr_lo" : "R3 addr_lo", {8'h0, addr_o[7:0]}, {8'h0, a[7:0]});
    chk("R4 mem_rd_n", {15'h0, mem_rd_n_o}, {15'h0, !mr});
    chk("R5 mem_wr_n", {15'h0, mem_wr_n_o}, {15'h0, !mw});
    chk("R6 io_rd_n",  {15'h0, io_rd_n_o},  {15'h0, !ir});
    chk("R6 io_wr_n",  {15'h0, io_wr_n_o},  {15'h0, !iw});
    chk("R7 cmd count", 16'(4 - $countones({mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o})),
        16'(mr + mw + ir + iw));
    chk("R8 cs_n", 16'(cs_n_o), 16'(cs));
    chk("R9 cpu_oe", {15'h0, cpu_oe_o}, {15'h0, rd_ok});
    chk("R9 sys_oe", {15'h0, sys_oe_o}, {15'h0, wr_ok});
    chk("R10 cpu_dat", {8'h0, cpu_dat_o}, {8'h0, rd_ok ? sys_dat_i : 8'h00});
    chk("R10 sys_dat", {8'h0, sys_dat_o}, {8'h0, wr_ok ? ad_i : 8'h00});
  endtask

  // One clock: drive at the falling edge, compare, then apply the capture
  // the coming rising edge will make.
  task automatic cyc(input logic stb, input logic [7:0] hi, input logic [7:0] ad,
                     input logic rdn, input logic wrn, input logic io, input logic [7:0] sd);
    @(negedge clk);
    addr_stb_i = stb; addr_hi_i = hi; ad_i = ad;
    rd_n_i = rdn; wr_n_i = wrn; io_sel_i = io; sys_dat_i = sd;
    #1;
    compare();
    if (stb) held_log.push_back(ad);
    if (held_log.size() > 0) held_ref = held_log.pop_front();
  endtask

  // A full bus cycle: address phase, then two data-phase clocks with a
  // changing byte on the shared lines.
  task automatic bus(input logic [15:0] a, input logic rdn, input logic wrn,
                     input logic io, input logic [7:0] d);
    cyc(1'b1, a[15:8], a[7:0], 1'b1, 1'b1, io, 8'h00);
    cyc(1'b0, a[15:8], d, rdn, wrn, io, ~d);
    cyc(1'b0, a[15:8], d ^ 8'h5A, rdn, wrn, io, d);
    chk("R3 held after data", {8'h0, addr_o[7:0]}, {8'h0, a[7:0]});
    cyc(1'b0, a[15:8], 8'hFF, 1'b1, 1'b1, io, 8'h00);
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    rst_n = 1'b0; addr_stb_i = 1'b0; addr_hi_i = 8'h00; ad_i = 8'h00;
    rd_n_i = 1'b1; wr_n_i = 1'b1; io_sel_i = 1'b0; sys_dat_i = 8'h00;
    held_ref = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1: cleared held byte visible with the strobe low.
    chk("R1 reset addr_lo", {8'h0, addr_o[7:0]}, 16'h0000);
    chk("R1 reset cmd idle", {12'h0, mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o}, 16'h000F);

    bus(16'h1234, 1'b0, 1'b1, 1'b0, 8'hA5);   // R4 memory read, region 4
    bus(16'h0755, 1'b1, 1'b0, 1'b0, 8'h3C);   // R5 memory write, region 1
    bus(16'h00C0, 1'b0, 1'b1, 1'b1, 8'h81);   // R6 I/O read, no selects
    bus(16'h0042, 1'b1, 1'b0, 1'b1, 8'h18);   // R6 I/O write
    bus(16'h1FFF, 1'b0, 1'b1, 1'b0, 8'h77);   // R8 last populated region 7
    bus(16'h2000, 1'b0, 1'b1, 1'b0, 8'h66);   // R8 region 8: nothing selected
    bus(16'hFC01, 1'b1, 1'b0, 1'b0, 8'h99);   // R8 top region
    bus(16'h0400, 1'b0, 1'b0, 1'b0, 8'hE1);   // R7 read and write together
    // R9: read requested during the address phase must stay off.
    cyc(1'b1, 8'h08, 8'h11, 1'b0, 1'b1, 1'b0, 8'h22);
    cyc(1'b1, 8'h08, 8'h12, 1'b1, 1'b0, 1'b1, 8'h22);
    cyc(1'b0, 8'h08, 8'h34, 1'b0, 1'b1, 1'b0, 8'h22);
    chk("R3 last strobe byte", {8'h0, addr_o[7:0]}, 16'h0012);

    lfsr = 32'hACE1_2B3D;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cyc(lfsr[0] & lfsr[5], {lfsr[15:13], lfsr[12:8]} & 8'h2F, lfsr[23:16],
          lfsr[1], lfsr[2], lfsr[3], lfsr[31:24]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule